// File: doc/BRIEF.md
# Packed Pairwise Multiply-Accumulate Unit

This block takes two 128-bit packed operands and a mode select. It multiplies each lane of the first operand by the lane at the same position in the second. It then adds the two products from each neighbouring pair of lanes into one result lane of double width. The result appears on a registered output one clock after a valid input.

There are two modes. Word mode treats both operands as signed 16-bit lanes. The pair sums fill 32-bit result lanes, and an overflowing sum wraps. Byte mode treats the first operand as unsigned bytes and the second operand as signed bytes. Each pair sum is clamped to the signed 16-bit range before it is packed into a 16-bit result lane.

Top module: `packed_madd`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid goes to 0 and result goes to all zeros.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high, and low after a cycle with in_valid low.
- R3: With mode = 0 (word mode), result lane k (bits 32k+31:32k) equals the signed product of 16-bit lane 2k of A and B plus the signed product of lane 2k+1 of A and B. Lane 0 is in the least significant bits.
- R4: Word mode does not saturate. The sum wraps to 32 bits, so when all four words in a pair are 0x8000 the result lane is 0x80000000.
- R5: With mode = 1 (byte mode), result lane k (bits 16k+15:16k) equals unsigned A byte 2k times signed B byte 2k, plus unsigned A byte 2k+1 times signed B byte 2k+1, whenever that sum lies within -32768..32767.
- R6: In byte mode, a pair sum above 32767 gives 0x7FFF and a pair sum below -32768 gives 0x8000.
- R7: When in_valid is low at a clock edge, result keeps its previous value, whatever mode, opnd_a and opnd_b carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 1 | 0 = signed word pairs, 1 = unsigned-by-signed byte pairs with saturation |
| opnd_a | input | 128 | First packed operand (unsigned bytes in byte mode) |
| opnd_b | input | 128 | Second packed operand (always signed) |
| out_valid | output | 1 | result holds a fresh value |
| result | output | 128 | Packed pairwise sums |

## Verification
Every result, and the out_valid that goes with it, is due exactly one clock edge after the edge that samples its operands. The bench drives each stimulus just after a falling edge. It then updates its lane-by-lane integer model at the next rising edge and compares the ports at the following falling edge, so each comparison is made exactly one register stage after its stimulus. Idle cycles use the same timing and check that the previous result is still held. Reset is checked at the falling edge after a rising edge with rst_n low.

// File: rtl/packed_madd_pkg.sv
// Shared types and lane widths for the packed pairwise multiply-accumulate unit.
package packed_madd_pkg;
    // Operating mode carried on the mode pin.
    typedef enum logic {
        MADD_WORDS = 1'b0,
        MADD_BYTES = 1'b1
    } madd_mode_e;

    localparam int WORD_LANE_W = 16;
    localparam int BYTE_LANE_W = 8;
endpackage

// File: rtl/word_pair_mac.sv
// word_pair_mac: multiplies two signed SRC_W-bit lane pairs and adds the two
// products into one 2*SRC_W-bit lane. The sum wraps with no saturation.
// Assumes both operands use two's complement.
module word_pair_mac #(
    parameter int SRC_W = 16,
    localparam int RES_W = 2 * SRC_W
) (
    input  logic [2*SRC_W-1:0] a_pair,
    input  logic [2*SRC_W-1:0] b_pair,
    output logic [RES_W-1:0]   sum_out
);
    logic signed [SRC_W-1:0] a_lo, a_hi, b_lo, b_hi;
    logic signed [RES_W-1:0] prod_lo, prod_hi;

    // Split the pair into its low and high lanes.
    always_comb begin
        a_lo = a_pair[SRC_W-1:0];
        a_hi = a_pair[2*SRC_W-1:SRC_W];
        b_lo = b_pair[SRC_W-1:0];
        b_hi = b_pair[2*SRC_W-1:SRC_W];
    end

    // Form the two full-width signed products and add them with wrap-around.
    always_comb begin
        prod_lo = RES_W'(a_lo) * RES_W'(b_lo);
        prod_hi = RES_W'(a_hi) * RES_W'(b_hi);
        sum_out = prod_lo + prod_hi;
    end
endmodule

// File: rtl/byte_pair_mac.sv
// byte_pair_mac: multiplies two unsigned A bytes by two signed B bytes, adds
// the pair of products, and clamps the sum to the signed RES_W-bit range.
// Assumes A lanes are unsigned and B lanes are two's complement.
module byte_pair_mac #(
    parameter int SRC_W = 8,
    parameter int RES_W = 2 * SRC_W,
    localparam int EXT_W = SRC_W + 1,
    localparam int PROD_W = 2 * EXT_W,
    localparam int SUM_W = PROD_W + 1
) (
    input  logic [2*SRC_W-1:0] a_pair,
    input  logic [2*SRC_W-1:0] b_pair,
    output logic [RES_W-1:0]   sum_out
);
    localparam int MAX_I = (1 << (RES_W - 1)) - 1;
    localparam int MIN_I = -(1 << (RES_W - 1));
    localparam logic [RES_W-1:0] MAX_V = MAX_I[RES_W-1:0];
    localparam logic [RES_W-1:0] MIN_V = MIN_I[RES_W-1:0];

    logic signed [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;
    logic signed [PROD_W-1:0] prod_lo, prod_hi;
    logic signed [SUM_W-1:0] wide_sum;

    // Extend A with a zero bit (unsigned) and B with its sign bit (signed).
    always_comb begin
        a_lo = {1'b0, a_pair[SRC_W-1:0]};
        a_hi = {1'b0, a_pair[2*SRC_W-1:SRC_W]};
        b_lo = {b_pair[SRC_W-1], b_pair[SRC_W-1:0]};
        b_hi = {b_pair[2*SRC_W-1], b_pair[2*SRC_W-1:SRC_W]};
    end

    // Multiply and add the pair at a width that cannot overflow.
    always_comb begin
        prod_lo  = PROD_W'(a_lo) * PROD_W'(b_lo);
        prod_hi  = PROD_W'(a_hi) * PROD_W'(b_hi);
        wide_sum = SUM_W'(prod_lo) + SUM_W'(prod_hi);
    end

    // Clamp the wide sum into the signed result range.
    always_comb begin
        if (int'(wide_sum) > MAX_I) begin
            sum_out = MAX_V;
        end else if (int'(wide_sum) < MIN_I) begin
            sum_out = MIN_V;
        end else begin
            sum_out = wide_sum[RES_W-1:0];
        end
    end
endmodule

// File: rtl/madd_out_stage.sv
// madd_out_stage: one register stage for the packed result and its valid flag.
// The data register loads only when the input is valid, so an idle cycle keeps
// the last result. Synchronous active-low reset clears both registers.
module madd_out_stage #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d_in,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_out
);
    // Track whether the stage holds a result from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= load;
    end

    // Capture new data on a valid cycle and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_out <= '0;
        else if (load) q_out <= d_in;
    end
endmodule

// File: rtl/packed_madd.sv
// packed_madd: packed pairwise multiply-accumulate over DATA_W-bit operands.
// mode 0 gives signed word pairs summed into wrapped 32-bit lanes. mode 1
// gives unsigned-A by signed-B byte pairs summed into saturated 16-bit lanes.
// Lane 0 is in the least significant bits. One cycle of latency.
// Assumes DATA_W is a multiple of 32.
module packed_madd #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    import packed_madd_pkg::*;

    localparam int WPAIR_W  = 2 * WORD_LANE_W;
    localparam int BPAIR_W  = 2 * BYTE_LANE_W;
    localparam int N_WPAIRS = DATA_W / WPAIR_W;
    localparam int N_BPAIRS = DATA_W / BPAIR_W;

    logic [DATA_W-1:0] word_res;
    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] next_res;
    madd_mode_e        mode_sel;

    // One signed word-pair unit for each 32-bit result lane.
    for (genvar k = 0; k < N_WPAIRS; k++) begin : g_word
        word_pair_mac #(.SRC_W(WORD_LANE_W)) u_wmac (
            .a_pair (opnd_a[k*WPAIR_W +: WPAIR_W]),
            .b_pair (opnd_b[k*WPAIR_W +: WPAIR_W]),
            .sum_out(word_res[k*WPAIR_W +: WPAIR_W])
        );
    end

    // One saturating byte-pair unit for each 16-bit result lane.
    for (genvar k = 0; k < N_BPAIRS; k++) begin : g_byte
        byte_pair_mac #(.SRC_W(BYTE_LANE_W), .RES_W(BPAIR_W)) u_bmac (
            .a_pair (opnd_a[k*BPAIR_W +: BPAIR_W]),
            .b_pair (opnd_b[k*BPAIR_W +: BPAIR_W]),
            .sum_out(byte_res[k*BPAIR_W +: BPAIR_W])
        );
    end

    // Pick the result of the selected mode.
    always_comb begin
        mode_sel = madd_mode_e'(mode);
        next_res = (mode_sel == MADD_BYTES) ? byte_res : word_res;
    end

    madd_out_stage #(.DATA_W(DATA_W)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (in_valid),
        .d_in   (next_res),
        .q_valid(out_valid),
        .q_out  (result)
    );
endmodule

// File: rtl/packed_madd_chk.sv
// packed_madd_chk: port-level properties for packed_madd, attached by bind.
module packed_madd_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mode,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    localparam logic [DATA_W-1:0] ALL_W_MIN  = {(DATA_W/16){16'h8000}};
    localparam logic [DATA_W-1:0] ALL_D_MIN  = {(DATA_W/32){32'h8000_0000}};
    localparam logic [DATA_W-1:0] ALL_FF     = {(DATA_W/8){8'hFF}};
    localparam logic [DATA_W-1:0] ALL_7F     = {(DATA_W/8){8'h7F}};
    localparam logic [DATA_W-1:0] ALL_80     = {(DATA_W/8){8'h80}};
    localparam logic [DATA_W-1:0] ALL_S_MAX  = {(DATA_W/16){16'h7FFF}};

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R4
    word_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode && opnd_a == ALL_W_MIN && opnd_b == ALL_W_MIN)
        |=> result == ALL_D_MIN);
    // R6
    byte_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode && opnd_a == ALL_FF && opnd_b == ALL_7F)
        |=> result == ALL_S_MAX);
    // R6
    byte_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode && opnd_a == ALL_FF && opnd_b == ALL_80)
        |=> result == ALL_W_MIN);
endmodule

bind packed_madd packed_madd_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .mode     (mode),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .out_valid(out_valid),
    .result   (result)
);

// File: tb/packed_madd_tb.sv
`timescale 1ns/1ps
// Bench for packed_madd: a behavioural lane-by-lane integer model, compared
// with the outputs at every falling edge.
module packed_madd_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         mode = 1'b0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic         exp_valid = 1'b0;
    logic [127:0] exp_res = '0;

    always #2.5 clk = ~clk;

    packed_madd u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
    );

    // Behavioural model of one packed operation.
    function automatic logic [127:0] model(input logic m, input logic [127:0] a,
                                           input logic [127:0] b);
        logic [127:0] r = '0;
        if (!m) begin
            for (int k = 0; k < 4; k++) begin
                longint s = 0;
                for (int j = 0; j < 2; j++) begin
                    longint x = longint'($signed(a[32*k+16*j +: 16]));
                    longint y = longint'($signed(b[32*k+16*j +: 16]));
                    s += x * y;
                end
                r[32*k +: 32] = s[31:0];
            end
        end else begin
            for (int k = 0; k < 8; k++) begin
                longint s = 0;
                for (int j = 0; j < 2; j++) begin
                    longint x = longint'(a[16*k+8*j +: 8]);
                    longint y = longint'($signed(b[16*k+8*j +: 8]));
                    s += x * y;
                end
                if (s > 32767) s = 32767;
                if (s < -32768) s = -32768;
                r[16*k +: 16] = s[15:0];
            end
        end
        return r;
    endfunction

    // Compare the ports against the model, once per call.
    task automatic compare(input string tag);
        n_cmp++;
        if (out_valid !== exp_valid || result !== exp_res) begin
            n_bad++;
            $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                     tag, out_valid, result, exp_valid, exp_res);
        end
    endtask

    // Apply one cycle of stimulus, advance the model at the rising edge,
    // then compare at the next falling edge.
    task automatic step(input logic v, input logic m, input logic [127:0] a,
                        input logic [127:0] b, input string tag);
        in_valid = v; mode = m; opnd_a = a; opnd_b = b;
        @(posedge clk);
        if (!rst_n) begin
            exp_valid = 1'b0; exp_res = '0;
        end else begin
            exp_valid = v;
            if (v) exp_res = model(m, a, b);
        end
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] lane_a;
        @(negedge clk);
        // R1: reset clears the outputs, even with valid input present.
        step(1'b1, 1'b0, '1, '1, "R1");
        step(1'b1, 1'b1, rnd128(), rnd128(), "R1");
        rst_n = 1'b1;

        // R3: lane order, word k of A = k+1, B = 1.
        for (int k = 0; k < 8; k++) lane_a[16*k +: 16] = 16'(k + 1);
        step(1'b1, 1'b0, lane_a, {8{16'h0001}}, "R3");
        step(1'b1, 1'b0, {8{16'hFFFF}}, {8{16'h7FFF}}, "R3");
        step(1'b1, 1'b0, {8{16'h7FFF}}, {8{16'h7FFF}}, "R3");
        // R4: wrap of the most negative pair.
        step(1'b1, 1'b0, {8{16'h8000}}, {8{16'h8000}}, "R4");
        step(1'b1, 1'b0, {8{16'h8000}}, {8{16'h7FFF}}, "R4");
        // R5: byte mode, mixed signedness, lane order.
        for (int k = 0; k < 16; k++) lane_a[8*k +: 8] = 8'(k);
        step(1'b1, 1'b1, lane_a, {16{8'hFF}}, "R5");
        step(1'b1, 1'b1, {16{8'h80}}, {16{8'h01}}, "R5");
        step(1'b1, 1'b1, {16{8'h00}}, {16{8'h80}}, "R5");
        step(1'b1, 1'b1, {8{16'h00FF}}, {8{16'h0080}}, "R5");
        // R6: clamp at both ends.
        step(1'b1, 1'b1, {16{8'hFF}}, {16{8'h7F}}, "R6");
        step(1'b1, 1'b1, {16{8'hFF}}, {16{8'h80}}, "R6");
        step(1'b1, 1'b1, {16{8'h80}}, {16{8'h7F}}, "R6");
        // R2 and R7: idle cycles keep the result whatever the inputs are.
        step(1'b0, 1'b0, rnd128(), rnd128(), "R7");
        step(1'b0, 1'b1, rnd128(), rnd128(), "R7");
        step(1'b1, 1'b0, rnd128(), rnd128(), "R2");
        step(1'b0, 1'b1, '1, '0, "R2");

        // Random mix of modes and idle cycles.
        for (int i = 0; i < 400; i++) begin
            logic v = ($urandom % 4) != 0;
            logic m = 1'($urandom);
            step(v, m, rnd128(), rnd128(), m ? "R5 R6 R7" : "R3 R4 R7");
        end

        // R1: reset in the middle of a run.
        rst_n = 1'b0;
        step(1'b1, 1'b1, rnd128(), rnd128(), "R1");
        rst_n = 1'b1;
        step(1'b0, 1'b0, '0, '0, "R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule